// File: doc/BRIEF.md
# Slot-Mapped Record Identifier Store

This block keeps the identifier map of a slotted record store. Every slot either holds a 64-bit record identifier or is empty, which is encoded as zero. Slots below a configured first-record index are kept for a store header. They are never handed out, so slot index 0 can stand for "no slot". Next to the map, the block keeps a running count of occupied slots.

A client pulses `start` with an operation code and a key. The four operations are lookup, allocate-probe, write (insert or overwrite) and clear. The block scans the map one entry per clock, starting at the first-record index. It then raises `done` for one cycle, with a slot index and a status code. The status codes are 0x00 success, 0x01 no space, 0x03 failed, 0x04 store empty and 0x05 not found.

A scan stops early once it has passed as many occupied entries as the count says exist. The copying of record payloads and the checking of the header are the job of neighbouring logic.

Top module: `slot_store_mgr`

## Requirements
- R1: After reset, `busy` and `done` are low, `rec_count` is 0 and every slot is empty.
- R2: The identifiers all-zeros and all-ones are reserved. A write or clear with either one, or a lookup with either one while the store is non-empty, completes in the cycle after `start` with status 0x03 and index 0, and changes nothing.
- R3: Op code 0 (lookup) returns 0x00 with the index of the slot that holds the key. If no slot holds the key, it returns 0x05 with index 0. Every non-success result carries index 0.
- R4: A scan examines one slot per clock from the first-record index upward. `done` follows the last slot examined by one edge. A lookup or clear ends at a match, at the last slot, or at the slot where the number of occupied slots passed reaches `rec_count`.
- R5: Op code 2 (write) with a key that is not stored places it in the lowest empty slot at or above the first-record index. It increments `rec_count` and returns 0x00 with that index. The count never exceeds the number of usable slots.
- R6: A write whose key is already stored returns that slot's index with 0x00 and leaves `rec_count` unchanged, even when a lower slot is empty.
- R7: A write of a new key when no usable slot is empty returns 0x01 with index 0 and changes nothing.
- R8: Op code 3 (clear) of a stored key empties its slot, decrements `rec_count` and returns 0x00 with the index. Clearing an absent key returns 0x05 and changes nothing.
- R9: Op code 1 (allocate-probe) returns the lowest empty usable slot with 0x00 without changing the map, or returns 0x01 when the store is full.
- R10: A successful result index lies in [first-record index, slot count). Slots below the first-record index are never written.
- R11: `done` is a one-cycle pulse. `res_idx` and `res_status` hold their values between pulses. A `start` while `busy` is high is ignored.
- R12: A lookup while `rec_count` is 0 completes in the cycle after `start` with status 0x04 and index 0. This takes priority over the reserved-key check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when not busy) |
| op | input | 2 | 0 lookup, 1 allocate-probe, 2 write, 3 clear |
| key | input | ID_W | Record identifier operand |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| res_idx | output | IDX_W | Resulting slot index, 0 for none |
| res_status | output | 8 | Completion status code |
| rec_count | output | CNT_W | Number of occupied slots |

## Verification
On every cycle the assertions check the shape of the handshake and the results. This covers the single-cycle `done` pulse, results that stay put between pulses, success indices inside the usable range, index 0 on every failure, a count bounded by the usable slots that moves only on a successful completion, and the no-space status appearing only with a full store. Only the bench's scenarios can show that the correct slot was chosen: lowest-empty allocation, overwrite in place, freed slots being reused, and the early-stop scan lengths. The same holds for the reserved identifiers and for a `start` during a scan leaving the map untouched.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_ALLOC  = 2'd1,
    OP_WRITE  = 2'd2,
    OP_CLEAR  = 2'd3
  } rsm_op_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SCAN = 1'b1
  } rsm_state_e;

  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_NOSPACE  = 8'h01;
  localparam logic [7:0] ST_FAIL     = 8'h03;
  localparam logic [7:0] ST_EMPTY    = 8'h04;
  localparam logic [7:0] ST_NOTFOUND = 8'h05;

endpackage

// File: rtl/rsm_map.sv
// Identifier map: one register per usable slot, reserved slots read as zero.
module rsm_map #(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 1,
  parameter int ID_W      = 64,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_data
);

  logic [ID_W-1:0] slot_w [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g < FIRST_IDX) begin : g_rsvd
      // header slots carry no storage
      assign slot_w[g] = '0;
    end else begin : g_used
      logic            wen;
      logic [ID_W-1:0] ent_q;
      // an index outside the slot range matches no slot: the write is dropped
      assign wen = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= '0;
        end else if (wen) begin
          ent_q <= wr_data;
        end
      end
      assign slot_w[g] = ent_q;
    end
  end

  assign rd_data = slot_w[rd_idx];

endmodule

// File: rtl/rsm_ctrl.sv
// Operation sequencer: handshake, one-entry-per-clock scan, record count.
module rsm_ctrl
  import rsm_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 1,
  parameter int ID_W      = 64,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [ID_W-1:0]  key,
  input  logic [ID_W-1:0]  rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [ID_W-1:0]  wr_data,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] res_idx,
  output logic [7:0]       res_status,
  output logic [CNT_W-1:0] rec_count
);

  localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(FIRST_IDX);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(NUM_SLOTS - 1);

  rsm_state_e       state_q, state_d;
  rsm_op_e          op_q, op_d;
  logic [ID_W-1:0]  key_q, key_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] passed_q, passed_d;
  logic             ev_q, ev_d;
  logic [IDX_W-1:0] eidx_q, eidx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] ridx_q, ridx_d;
  logic [7:0]       rst_q, rst_d;

  logic             nz, hit, srch_end, last, cand_v, key_ok;
  logic [CNT_W-1:0] passed_n;
  logic [IDX_W-1:0] cand_idx;

  assign rd_idx   = idx_q;
  assign nz       = (rd_data != '0);
  assign hit      = nz && (rd_data == key_q);
  assign passed_n = passed_q + CNT_W'(nz);
  assign srch_end = (passed_n >= cnt_q);
  assign last     = (idx_q == LAST_I);
  assign cand_v   = ev_q || !nz;
  assign cand_idx = ev_q ? eidx_q : idx_q;
  assign key_ok   = (key != '0) && (key != '1);

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    key_d    = key_q;
    idx_d    = idx_q;
    passed_d = passed_q;
    ev_d     = ev_q;
    eidx_d   = eidx_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    ridx_d   = ridx_q;
    rst_d    = rst_q;
    wr_en    = 1'b0;
    wr_idx   = idx_q;
    wr_data  = '0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          op_d     = rsm_op_e'(op);
          key_d    = key;
          idx_d    = FIRST_I;
          passed_d = '0;
          ev_d     = 1'b0;
          if ((rsm_op_e'(op) == OP_LOOKUP) && (cnt_q == '0)) begin
            done_d = 1'b1;
            ridx_d = '0;
            rst_d  = ST_EMPTY;
          end else if ((rsm_op_e'(op) != OP_ALLOC) && !key_ok) begin
            done_d = 1'b1;
            ridx_d = '0;
            rst_d  = ST_FAIL;
          end else begin
            state_d = S_SCAN;
          end
        end
      end
      S_SCAN: begin
        idx_d    = idx_q + 1'b1;
        passed_d = passed_n;
        case (op_q)
          OP_LOOKUP, OP_CLEAR: begin
            if (hit) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = idx_q;
              rst_d   = ST_OK;
              if (op_q == OP_CLEAR) begin
                wr_en = 1'b1;
                cnt_d = cnt_q - 1'b1;
              end
            end else if (srch_end || last) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = '0;
              rst_d   = ST_NOTFOUND;
            end
          end
          OP_ALLOC: begin
            if (!nz) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = idx_q;
              rst_d   = ST_OK;
            end else if (last) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = '0;
              rst_d   = ST_NOSPACE;
            end
          end
          default: begin
            if (hit) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = idx_q;
              rst_d   = ST_OK;
              wr_en   = 1'b1;
              wr_data = key_q;
            end else if ((srch_end || last) && cand_v) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = cand_idx;
              rst_d   = ST_OK;
              wr_en   = 1'b1;
              wr_idx  = cand_idx;
              wr_data = key_q;
              cnt_d   = cnt_q + 1'b1;
            end else if (last) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              ridx_d  = '0;
              rst_d   = ST_NOSPACE;
            end else if (!ev_q && !nz) begin
              ev_d   = 1'b1;
              eidx_d = idx_q;
            end
          end
        endcase
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_LOOKUP;
      key_q    <= '0;
      idx_q    <= '0;
      passed_q <= '0;
      ev_q     <= 1'b0;
      eidx_q   <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      ridx_q   <= '0;
      rst_q    <= ST_OK;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      key_q    <= key_d;
      idx_q    <= idx_d;
      passed_q <= passed_d;
      ev_q     <= ev_d;
      eidx_q   <= eidx_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      ridx_q   <= ridx_d;
      rst_q    <= rst_d;
    end
  end

  assign busy       = (state_q == S_SCAN);
  assign done       = done_q;
  assign res_idx    = ridx_q;
  assign res_status = rst_q;
  assign rec_count  = cnt_q;

endmodule

// File: rtl/slot_store_mgr.sv
// Top: identifier map plus sequencer. Reset is asserted asynchronously and
// is expected to be released synchronously by the reset tree upstream.
module slot_store_mgr #(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 1,
  parameter int ID_W      = 64,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [ID_W-1:0]  key,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] res_idx,
  output logic [7:0]       res_status,
  output logic [CNT_W-1:0] rec_count
);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [ID_W-1:0]  wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic [ID_W-1:0]  rd_data;

  rsm_map #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIRST_IDX (FIRST_IDX),
    .ID_W      (ID_W),
    .IDX_W     (IDX_W)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  rsm_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIRST_IDX (FIRST_IDX),
    .ID_W      (ID_W),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .key        (key),
    .rd_data    (rd_data),
    .rd_idx     (rd_idx),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .busy       (busy),
    .done       (done),
    .res_idx    (res_idx),
    .res_status (res_status),
    .rec_count  (rec_count)
  );

endmodule

// File: rtl/slot_store_mgr_chk.sv
module slot_store_mgr_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 1,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] res_idx,
  input logic [7:0]       res_status,
  input logic [CNT_W-1:0] rec_count
);

  localparam logic [CNT_W-1:0] USABLE = CNT_W'(NUM_SLOTS - FIRST_IDX);
  localparam logic [IDX_W:0]   LO     = (IDX_W+1)'(FIRST_IDX);
  localparam logic [IDX_W:0]   HI     = (IDX_W+1)'(NUM_SLOTS);

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= USABLE); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start))); // R11

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_idx) && $stable(res_status))); // R11

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_status == 8'h00) |-> ({1'b0, res_idx} >= LO && {1'b0, res_idx} < HI)); // R10

  AST_IDX_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_status != 8'h00) |-> (res_idx == '0)); // R3

  AST_COUNT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_count) |-> (done && res_status == 8'h00)); // R8

  AST_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_status == 8'h01) |-> (rec_count == USABLE)); // R7

endmodule

bind slot_store_mgr slot_store_mgr_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .FIRST_IDX (FIRST_IDX),
  .IDX_W     (IDX_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .res_idx    (res_idx),
  .res_status (res_status),
  .rec_count  (rec_count)
);

// File: tb/tb_slot_store_mgr.sv
`timescale 1ns/1ps
module tb_slot_store_mgr;

  localparam int NS    = 8;
  localparam int FI    = 2;
  localparam int IW    = 64;
  localparam int IDX_W = $clog2(NS);
  localparam int CNT_W = $clog2(NS + 1);

  localparam logic [1:0] OPL = 2'd0, OPA = 2'd1, OPW = 2'd2, OPC = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [1:0]       op;
  logic [IW-1:0]    key;
  logic             busy, done;
  logic [IDX_W-1:0] res_idx;
  logic [7:0]       res_status;
  logic [CNT_W-1:0] rec_count;

  int errors = 0;
  int checks = 0;

  logic [IW-1:0] m [NS];
  int            mcnt;

  always #2 clk = ~clk;

  slot_store_mgr #(.NUM_SLOTS(NS), .FIRST_IDX(FI), .ID_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .key(key),
    .busy(busy), .done(done), .res_idx(res_idx), .res_status(res_status),
    .rec_count(rec_count)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] idv(input int n);
    return 64'hC3A5_0000_0000_0000 | (64'(n) * 64'h0001_0001_0011);
  endfunction

  // expected outcome from the requirements; updates the bench's map model
  task automatic model_op(input logic [1:0] o, input logic [IW-1:0] k,
                          output logic [7:0] st, output int ix, output int lat);
    int  passed;
    bit  ev, nz, last;
    int  ei;
    st = 8'h05; ix = 0; lat = 0; passed = 0; ev = 0; ei = 0;
    if (o == OPL && mcnt == 0) begin st = 8'h04; return; end
    if (o != OPA && (k == '0 || k == '1)) begin st = 8'h03; return; end
    for (int i = FI; i < NS; i++) begin
      lat++;
      nz   = (m[i] != '0);
      last = (i == NS - 1);
      if (nz) passed++;
      if (o == OPL || o == OPC) begin
        if (nz && m[i] == k) begin
          st = 8'h00; ix = i;
          if (o == OPC) begin m[i] = '0; mcnt--; end
          return;
        end
        if (passed >= mcnt || last) begin st = 8'h05; return; end
      end else if (o == OPA) begin
        if (!nz) begin st = 8'h00; ix = i; return; end
        if (last) begin st = 8'h01; return; end
      end else begin
        if (nz && m[i] == k) begin st = 8'h00; ix = i; return; end
        if (!nz && !ev) begin ev = 1; ei = i; end
        if ((passed >= mcnt || last) && ev) begin
          st = 8'h00; ix = ei; m[ei] = k; mcnt++; return;
        end
        if (last) begin st = 8'h01; return; end
      end
    end
  endtask

  task automatic drive_wait(input logic [1:0] o, input logic [IW-1:0] k, output int lat);
    @(negedge clk);
    start = 1'b1; op = o; key = k;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [IW-1:0] k, input string tag);
    logic [7:0] est;
    int         eix, elat, lat;
    model_op(o, k, est, eix, elat);
    drive_wait(o, k, lat);
    check(res_status == est, {tag, " status"}, longint'(res_status), longint'(est));
    check(int'(res_idx) == eix, {tag, " index"}, longint'(res_idx), longint'(eix));
    check(int'(rec_count) == mcnt, {tag, " count"}, longint'(rec_count), longint'(mcnt));
    check(lat == elat, {"R4 latency ", tag}, longint'(lat), longint'(elat));
  endtask

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      OPL: return "R3";
      OPA: return "R9";
      OPW: return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] est;
    int         eix, elat, lat;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) m[i] = '0;
    mcnt  = 0;
    rst_n = 1'b0; start = 1'b0; op = OPL; key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", longint'(busy), 0);
    check(done == 1'b0, "R1 done", longint'(done), 0);
    check(rec_count == '0, "R1 count", longint'(rec_count), 0);

    run_op(OPL, idv(1), "R12 empty lookup");
    run_op(OPA, '0, "R9 probe empty");
    run_op(OPW, idv(1), "R5 first write");           // lands at FI, R10
    run_op(OPL, idv(2), "R4 early stop");            // one occupied, stops after slot FI
    run_op(OPW, '0, "R2 zero id");
    run_op(OPW, '1, "R2 ones id");
    run_op(OPC, '1, "R2 clear ones");
    run_op(OPL, '0, "R2 lookup zero");
    run_op(OPW, idv(2), "R5 second write");
    run_op(OPW, idv(3), "R5 third write");
    run_op(OPC, idv(1), "R8 clear present");
    run_op(OPC, idv(1), "R8 clear absent");
    run_op(OPL, idv(1), "R8 cleared gone");
    run_op(OPW, idv(3), "R6 overwrite");             // lower slot empty, stays put
    run_op(OPW, idv(4), "R5 reuse lowest");
    run_op(OPA, '0, "R9 probe");
    run_op(OPW, idv(5), "R5 fill");
    run_op(OPW, idv(6), "R5 fill");
    run_op(OPW, idv(7), "R5 fill");
    run_op(OPW, idv(8), "R7 full");
    run_op(OPA, '0, "R9 probe full");
    run_op(OPW, idv(7), "R6 overwrite full");
    run_op(OPL, idv(8), "R7 not stored");

    // R11: start during a scan is ignored
    model_op(OPL, idv(7), est, eix, elat);
    @(negedge clk);
    start = 1'b1; op = OPL; key = idv(7);
    @(negedge clk);
    op = OPC; key = idv(2);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    check(res_status == est, "R11 busy start status", longint'(res_status), longint'(est));
    check(int'(res_idx) == eix, "R11 busy start index", longint'(res_idx), longint'(eix));
    @(negedge clk);
    check(done == 1'b0, "R11 done pulse", longint'(done), 0);
    check(int'(rec_count) == mcnt, "R11 count kept", longint'(rec_count), longint'(mcnt));
    run_op(OPL, idv(2), "R11 key survives");

    for (int n = 0; n < 400; n++) begin
      logic [1:0]    o;
      logic [IW-1:0] k;
      int            r;
      o = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 11);
      k = (r == 0) ? '0 : (r == 1) ? '1 : idv(r);
      if (o == OPA) k = '0;
      run_op(o, k, op_tag(o));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule